// File: doc/BRIEF.md
# Power-Fail-Safe Twin-Copy Value Committer

This block stores an 8-bit counter value in a byte-wide nonvolatile memory so that power can be lost at any instant without losing the value. The memory holds two copies of the value. Each copy has a whole flag byte beside it that marks it trustworthy. A commit rewrites the copies one after the other, and each copy is bracketed by a flag write: first the flag is cleared, then the data byte is written, then the flag is set. While one copy is being rewritten the other copy is intact and marked valid. An interrupted commit therefore always leaves a usable value, either the old one or the new one.

After reset the block reads the memory back. It trusts copy one only if copy one's flag byte holds exactly the valid pattern. Otherwise it falls back to copy two under the same test. If neither flag is valid, it reports zero with an error flag. Software sees a one-shot commit request with a busy/done handshake. The memory side is a request/ready port, and the block holds each access until the memory accepts it.

States: `ST_BOOT` (reset hold), `ST_RD_F1`, `ST_RD_D1`, `ST_RD_F2`, `ST_RD_D2` (recovery reads), `ST_IDLE`, `ST_W1_CLR`, `ST_W1_DAT`, `ST_W1_SET`, `ST_W2_CLR`, `ST_W2_DAT`, `ST_W2_SET` (commit writes).

Transitions:
- `ST_BOOT` goes to `ST_RD_F1` on the first clock after reset.
- `ST_RD_F1` goes to `ST_RD_D1` if the flag is valid, or to `ST_RD_F2` if it is not.
- `ST_RD_F2` goes to `ST_RD_D2` if the flag is valid, or to `ST_IDLE` with an error if it is not.
- Both data reads go to `ST_IDLE`.
- `ST_IDLE` goes to `ST_W1_CLR` on a commit request.
- The write states then advance in the order listed above, each on an accepted transfer.
- `ST_W2_SET` returns to `ST_IDLE`.

Top module: `twin_commit_seq`

## Requirements
- R1: While reset is held, `busy` is 1 and `mem_req`, `done`, `rec_done` are 0. The first memory access after reset is a read of copy one's flag.
- R2: Memory layout: copy-one flag at address 0, copy-one data at 1, copy-two flag at 2, copy-two data at 3. If copy one's flag reads 0xA5, recovery reads address 1 next. It then raises `rec_done` with `rec_val` equal to that byte and `rec_err` 0.
- R3: If copy one's flag is not 0xA5, recovery reads address 2. If that byte is 0xA5, recovery reads address 3 and reports its value with `rec_err` 0.
- R4: Any flag byte other than 0xA5 counts as invalid. When both flags are invalid, `rec_done` rises with `rec_val` 0 and `rec_err` 1.
- R5: A commit request is taken only when the block is idle after recovery. It produces exactly six writes, in this order: (0,0x00), (1,value), (0,0xA5), (2,0x00), (3,value), (2,0xA5).
- R6: A memory access is held until `mem_ready` is 1. While it waits, its address, write data and direction do not change.
- R7: `busy` is 1 from the cycle after acceptance until the last flag write is taken. `done` is 1 for exactly the one cycle after that, and `busy` is 0 in that cycle.
- R8: A commit request that arrives while `busy` is 1 is ignored. The write sequence in progress keeps the value it was started with, and no extra writes follow.
- R9: If power is lost during any write of a commit, and the byte being written is corrupted, the value recovered afterwards is as follows. It is the previous value if the loss hit one of the first three writes. It is the new value if the loss hit one of the last three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (power-up) |
| commit_req | input | 1 | Request to store `commit_val` |
| commit_val | input | DW | Value to store |
| busy | output | 1 | Recovery or commit in progress |
| done | output | 1 | One-cycle pulse after a commit finishes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid when `mem_ready` is 1 |
| mem_ready | input | 1 | Memory accepts the access in this cycle |
| rec_done | output | 1 | Recovery finished |
| rec_val | output | DW | Recovered value |
| rec_err | output | 1 | Neither copy was valid |

## Verification
The bench cuts power at each of the six write steps in turn and corrupts the byte that was being written. A design that wrote both copies' flags before their data, or that cleared copy two early, would then recover a garbage or stale value. Flag bytes one bit away from the valid pattern are planted to catch a recovery that tests a single bit. Commit requests are fired while the block is busy, which exposes a design that re-latches the value or restarts the sequence. Random `mem_ready` stalls are applied to show any access that moves on before acceptance, or that changes its address while waiting.

// File: rtl/twin_commit_pkg.sv
package twin_commit_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_RD_F1,
        ST_RD_D1,
        ST_RD_F2,
        ST_RD_D2,
        ST_IDLE,
        ST_W1_CLR,
        ST_W1_DAT,
        ST_W1_SET,
        ST_W2_CLR,
        ST_W2_DAT,
        ST_W2_SET
    } tc_state_e;

endpackage

// File: rtl/tc_flag_check.sv
module tc_flag_check #(
    parameter int             DW      = 8,
    parameter logic [DW-1:0]  FLAG_OK = 'hA5
) (
    input  logic [DW-1:0] byte_i,
    output logic          ok_o
);
    // Whole-byte match: a single flipped bit makes the copy untrusted.
    assign ok_o = (byte_i == FLAG_OK);
endmodule

// File: rtl/tc_port_plan.sv
module tc_port_plan
    import twin_commit_pkg::*;
#(
    parameter int             DW       = 8,
    parameter int             AW       = 4,
    parameter int             BASE     = 0,
    parameter logic [DW-1:0]  FLAG_OK  = 'hA5,
    parameter logic [DW-1:0]  FLAG_BAD = '0
) (
    input  tc_state_e     st_i,
    input  logic [DW-1:0] val_i,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o
);
    localparam logic [AW-1:0] A_F1 = AW'(BASE);
    localparam logic [AW-1:0] A_D1 = AW'(BASE + 1);
    localparam logic [AW-1:0] A_F2 = AW'(BASE + 2);
    localparam logic [AW-1:0] A_D2 = AW'(BASE + 3);

    always_comb begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = A_F1;
        wdata_o = FLAG_BAD;
        unique case (st_i)
            ST_BOOT, ST_IDLE: begin
                req_o = 1'b0;
                we_o  = 1'b0;
            end
            ST_RD_F1:  we_o = 1'b0;
            ST_RD_D1:  begin we_o = 1'b0; addr_o = A_D1; end
            ST_RD_F2:  begin we_o = 1'b0; addr_o = A_F2; end
            ST_RD_D2:  begin we_o = 1'b0; addr_o = A_D2; end
            ST_W1_CLR: wdata_o = FLAG_BAD;
            ST_W1_DAT: begin addr_o = A_D1; wdata_o = val_i; end
            ST_W1_SET: wdata_o = FLAG_OK;
            ST_W2_CLR: addr_o = A_F2;
            ST_W2_DAT: begin addr_o = A_D2; wdata_o = val_i; end
            ST_W2_SET: begin addr_o = A_F2; wdata_o = FLAG_OK; end
            default: begin
                req_o = 1'b0;
                we_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/twin_commit_seq.sv
module twin_commit_seq
    import twin_commit_pkg::*;
#(
    parameter int             DW       = 8,
    parameter int             AW       = 4,
    parameter int             BASE     = 0,
    parameter logic [DW-1:0]  FLAG_OK  = 'hA5,
    parameter logic [DW-1:0]  FLAG_BAD = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_req,
    input  logic [DW-1:0] commit_val,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          rec_done,
    output logic [DW-1:0] rec_val,
    output logic          rec_err
);
    tc_state_e     st_q, st_d;
    logic [DW-1:0] val_q;
    logic          done_q, rdone_q, rerr_q;
    logic [DW-1:0] rval_q;
    logic          xfer, rd_ok;

    tc_flag_check #(.DW(DW), .FLAG_OK(FLAG_OK)) u_chk (
        .byte_i (mem_rdata),
        .ok_o   (rd_ok)
    );

    tc_port_plan #(
        .DW(DW), .AW(AW), .BASE(BASE), .FLAG_OK(FLAG_OK), .FLAG_BAD(FLAG_BAD)
    ) u_plan (
        .st_i    (st_q),
        .val_i   (val_q),
        .req_o   (mem_req),
        .we_o    (mem_we),
        .addr_o  (mem_addr),
        .wdata_o (mem_wdata)
    );

    assign xfer = mem_req && mem_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BOOT:   st_d = ST_RD_F1;
            ST_RD_F1:  if (xfer) st_d = rd_ok ? ST_RD_D1 : ST_RD_F2;
            ST_RD_D1:  if (xfer) st_d = ST_IDLE;
            ST_RD_F2:  if (xfer) st_d = rd_ok ? ST_RD_D2 : ST_IDLE;
            ST_RD_D2:  if (xfer) st_d = ST_IDLE;
            ST_IDLE:   if (commit_req) st_d = ST_W1_CLR;
            ST_W1_CLR: if (xfer) st_d = ST_W1_DAT;
            ST_W1_DAT: if (xfer) st_d = ST_W1_SET;
            ST_W1_SET: if (xfer) st_d = ST_W2_CLR;
            ST_W2_CLR: if (xfer) st_d = ST_W2_DAT;
            ST_W2_DAT: if (xfer) st_d = ST_W2_SET;
            ST_W2_SET: if (xfer) st_d = ST_IDLE;
            default:   st_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_BOOT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q   <= '0;
            done_q  <= 1'b0;
            rdone_q <= 1'b0;
            rerr_q  <= 1'b0;
            rval_q  <= '0;
        end else begin
            done_q <= (st_q == ST_W2_SET) && xfer;
            if (st_q == ST_IDLE && commit_req) val_q <= commit_val;
            if (xfer && (st_q == ST_RD_D1 || st_q == ST_RD_D2)) begin
                rval_q  <= mem_rdata;
                rdone_q <= 1'b1;
            end
            if (xfer && st_q == ST_RD_F2 && !rd_ok) begin
                rval_q  <= '0;
                rerr_q  <= 1'b1;
                rdone_q <= 1'b1;
            end
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign rec_done = rdone_q;
    assign rec_val  = rval_q;
    assign rec_err  = rerr_q;

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_err |-> (rec_done && rec_val == '0));

    // R8
    held_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rec_done) |=> (!busy || $stable(val_q)));

    // R5
    no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> rec_done);

endmodule

// File: tb/twin_commit_seq_tb_top.sv
`timescale 1ns/1ps
module twin_commit_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       commit_req = 1'b0;
    logic [7:0] commit_val = '0;
    logic       busy, done, mem_req, mem_we, rec_done, rec_err;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, rec_val;
    logic       mem_ready = 1'b0;

    always #2.5 clk = ~clk;

    twin_commit_seq dut_i (
        .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .commit_val(commit_val),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .rec_done(rec_done), .rec_val(rec_val), .rec_err(rec_err)
    );

    logic [7:0] mem [0:15];
    assign mem_rdata = mem[mem_addr];

    int vectors = 0, fails = 0;
    int wr_a_q[$], wr_d_q[$], rd_q[$];
    bit exp_busy = 1, exp_done = 0, exp_rdone = 0, exp_rerr = 0;
    int exp_rval = 0, pending = 0, last_good = 0, hold_at = -1;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(bit cr, int cv);
        @(negedge clk);
        chk(busy == exp_busy, "R7 busy", busy, exp_busy);
        chk(done == exp_done, "R7 done pulse", done, exp_done);
        chk(rec_done == exp_rdone, "R2 rec_done", rec_done, exp_rdone);
        if (exp_rdone) begin
            chk(rec_val == exp_rval[7:0], "R3 rec_val", rec_val, exp_rval);
            chk(rec_err == exp_rerr, "R4 rec_err", rec_err, exp_rerr);
        end
        exp_done = 0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = lfsr[0] | lfsr[3];
        if (hold_at >= 0 && wr_a_q.size() == 6 - hold_at) mem_ready = 1'b0;
        commit_req = cr;
        commit_val = cv[7:0];
        if (cr && !exp_busy && exp_rdone) begin
            pending = cv;
            wr_a_q = {0, 1, 0, 2, 3, 2};
            wr_d_q = {8'h00, cv, 8'hA5, 8'h00, cv, 8'hA5};
        end
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                if (wr_a_q.size() == 0) chk(0, "R5 unexpected write", mem_addr, -1);
                else begin
                    int ea, ed;
                    ea = wr_a_q.pop_front();
                    ed = wr_d_q.pop_front();
                    chk(mem_addr == ea, "R5 write addr", mem_addr, ea);
                    chk(mem_wdata == ed[7:0], "R8 write data", mem_wdata, ed);
                    mem[mem_addr] = mem_wdata;
                    if (wr_a_q.size() == 0) begin
                        exp_done = 1;
                        last_good = pending;
                    end
                end
            end else begin
                if (rd_q.size() == 0) chk(0, "R1 unexpected read", mem_addr, -1);
                else begin
                    int ra;
                    ra = rd_q.pop_front();
                    chk(mem_addr == ra, "R3 read addr", mem_addr, ra);
                    if (rd_q.size() == 0) exp_rdone = 1;
                end
            end
        end
        exp_busy = (rd_q.size() != 0) || (wr_a_q.size() != 0);
    endtask

    task automatic power_cycle(bit corrupt);
        @(negedge clk);
        if (corrupt && mem_req && mem_we) mem[mem_addr] = 8'h3C;
        mem_ready = 1'b0;
        commit_req = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(busy == 1'b1, "R1 reset busy", busy, 1);
        chk(mem_req == 1'b0, "R1 reset mem_req", mem_req, 0);
        chk(done == 1'b0 && rec_done == 1'b0, "R1 reset done flags", {done, rec_done}, 0);
        @(negedge clk);
        @(negedge clk);
        wr_a_q = {};
        wr_d_q = {};
        rd_q = {0};
        if (mem[0] == 8'hA5) begin
            rd_q.push_back(1); exp_rval = mem[1]; exp_rerr = 0;
        end else begin
            rd_q.push_back(2);
            if (mem[2] == 8'hA5) begin
                rd_q.push_back(3); exp_rval = mem[3]; exp_rerr = 0;
            end else begin
                exp_rval = 0; exp_rerr = 1;
            end
        end
        exp_busy = 1; exp_done = 0; exp_rdone = 0; hold_at = -1;
        rst_n = 1'b1;
        for (int i = 0; i < 60 && !(exp_rdone && !exp_busy); i++) tick(0, 0);
        tick(0, 0);
    endtask

    task automatic commit(int v, bit poke_busy);
        for (int i = 0; i < 60 && exp_busy; i++) tick(0, 0);
        tick(1, v);
        if (poke_busy) for (int i = 0; i < 4; i++) tick(1, v ^ 8'h5A);
        for (int i = 0; i < 80 && exp_busy; i++) tick(0, 0);
        tick(0, 0);
    endtask

    task automatic abort_at(int k, int v);
        int old;
        old = last_good;
        for (int i = 0; i < 60 && exp_busy; i++) tick(0, 0);
        hold_at = k;
        tick(1, v);
        for (int i = 0; i < 80 && !(wr_a_q.size() == 6 - k && mem_req && mem_we); i++) tick(0, 0);
        power_cycle(1);
        // R9: first three steps fall back to the old copy, last three keep the new one
        chk(rec_val == ((k < 3) ? old[7:0] : v[7:0]), "R9 recovered after abort",
            rec_val, (k < 3) ? old : v);
        chk(rec_err == 1'b0, "R9 no error after abort", rec_err, 0);
        last_good = (k < 3) ? old : v;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        power_cycle(0);
        chk(rec_err == 1'b1 && rec_val == 8'h00, "R4 blank memory", {rec_err, rec_val}, 9'h100);
        commit(8'h11, 1);
        commit(8'hA5, 0);
        commit(8'h00, 0);
        commit(8'hFF, 0);
        commit(8'h11, 1);
        power_cycle(0);
        chk(rec_val == 8'h11 && rec_err == 1'b0, "R2 copy one used", rec_val, 8'h11);
        for (int k = 0; k < 6; k++) abort_at(k, 8'h30 + k);
        commit(8'h77, 0);
        mem[0] = 8'hA4; mem[2] = 8'hA5; mem[3] = 8'h5E;
        power_cycle(0);
        chk(rec_val == 8'h5E, "R3 copy two fallback", rec_val, 8'h5E);
        mem[0] = 8'h00; mem[2] = 8'h25;
        power_cycle(0);
        chk(rec_err == 1'b1 && rec_val == 8'h00, "R4 both flags bad", {rec_err, rec_val}, 9'h100);
        commit(8'h42, 1);
        power_cycle(0);
        chk(rec_val == 8'h42, "R5 commit after error", rec_val, 8'h42);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule